// File: doc/BRIEF.md
# DMA Channel Register Port

This block is the register front end of a four-channel DMA engine. Software reaches it through an 8-bit I/O port with a 4-bit offset. Each channel holds a 16-bit start address and a 16-bit transfer count, each kept as a base copy and a current copy. Every location is one byte wide, so software reaches a 16-bit value through one offset in two accesses. A single pointer flip-flop, shared by all channels, picks the byte. Software sets it to a known state with a command write and then has to keep track of it.

Next to the channel registers the port holds a command byte, a per-channel mask and a status byte of terminal-count flags. It also decodes a master-clear command. The transfer sequencer sits outside this block. It uses a per-channel step strobe to advance the current address and count, and a per-channel reload strobe to restore them from the base copies.

Top module: `dma_regport`

## Requirements
- R1: After reset the mask is 4'hF (all channels masked), the command byte and the terminal-count flags are zero, the pointer selects the low byte, and every channel register is 16'h0000.
- R2: Channel n's address register is at offset 2n and its count register at offset 2n+1 (offsets 0x0 to 0x7). When the pointer is clear an access reaches bits [7:0]; when it is set, bits [15:8]. The pointer flips after every read or write of any channel register, so all channels share it.
- R3: A write of any data to offset 0xC clears the pointer, and the next channel access reaches the low byte.
- R4: A channel write loads the selected byte into both the base and the current copy. A channel read returns the selected byte of the current copy on rdata_o in the same cycle that rd_i is high. rdata_o is 8'h00 whenever rd_i is low.
- R5: A write to offset 0x8 loads the command byte onto cmd_o. A read of offset 0x8 returns {4'b0, terminal-count flags} with bit n for channel n, and it clears those flags unless a channel sets its flag in the same cycle.
- R6: A write to offset 0xD (master clear) clears the pointer, the command byte and the flags and sets the mask to 4'hF. The channel registers keep their values.
- R7: Mask control works as follows. A write to 0xA sets the mask bit of channel wdata[1:0] when wdata[2] is 1 and clears it when wdata[2] is 0. A write to 0xE clears all mask bits. A write to 0xF loads the mask from wdata[3:0].
- R8: step_i[n] adds one to channel n's current address (modulo 2^16) and subtracts one from its current count. A step taken at count 0 sets the channel's terminal-count flag and wraps the count to 16'hFFFF, so a programmed count N gives N+1 transfers.
- R9: reload_i[n] copies channel n's base address and base count into the current copies. Per channel, a register write overrides reload, and reload overrides step.
- R10: Reads of offsets 0x9 to 0xF and writes to 0x9, 0xB, 0xE and 0xF leave the pointer unchanged. Reads of offsets 0x9 to 0xF return 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| step_i | input | 4 | Per-channel transfer step from the sequencer |
| reload_i | input | 4 | Per-channel reload of current copies from base |
| cur_addr_o | output | 64 | Current addresses, channel n in bits [16n+15:16n] |
| cur_cnt_o | output | 64 | Current counts, channel n in bits [16n+15:16n] |
| cmd_o | output | 8 | Command byte |
| mask_o | output | 4 | Channel mask, 1 = masked |
| tc_o | output | 4 | Terminal-count flags |

## Verification
The assertions assume that wr_i and rd_i are never high together. The decoder gives the write priority if they are, but the pointer checks do not model that case. They also assume that step_i and reload_i are single-cycle pulses from a well-behaved sequencer, and that addr_i is stable while a strobe is high. The stimulus drives one strobe per cycle from a single task, always with a full-cycle pulse. It raises step or reload together with a write only in the cases written to test R9 priority. It keeps its own model of the pointer state, so every expected byte is known before the access.

// File: rtl/dma_regport_pkg.sv
package dma_regport_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int OFS_W  = 4;

  localparam logic [OFS_W-1:0] OFS_CMD        = 4'h8;
  localparam logic [OFS_W-1:0] OFS_SGL_MASK   = 4'hA;
  localparam logic [OFS_W-1:0] OFS_CLR_PTR    = 4'hC;
  localparam logic [OFS_W-1:0] OFS_MCLR       = 4'hD;
  localparam logic [OFS_W-1:0] OFS_UNMASK_ALL = 4'hE;
  localparam logic [OFS_W-1:0] OFS_MASK_ALL   = 4'hF;

  typedef struct packed {
    logic       chan_wr;
    logic       chan_rd;
    logic [1:0] chan;
    logic       is_cnt;
    logic       cmd_wr;
    logic       stat_rd;
    logic       sgl_mask_wr;
    logic       clr_ptr;
    logic       mclr;
    logic       unmask_all;
    logic       mask_all_wr;
  } dec_t;
endpackage

// File: rtl/dma_regport_dec.sv
module dma_regport_dec
  import dma_regport_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [OFS_W-1:0] addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output dec_t             dec_o
);
  logic chan_ok;
  logic rd_only;

  generate
    if (NUM_CH >= 4) begin : g_full
      assign chan_ok = 1'b1;
    end else begin : g_part
      assign chan_ok = (int'(addr_i[2:1]) < NUM_CH);
    end
  endgenerate

  // write wins if both strobes are high
  assign rd_only = rd_i & ~wr_i;

  always_comb begin
    dec_o        = '0;
    dec_o.chan   = addr_i[2:1];
    dec_o.is_cnt = addr_i[0];
    if (!addr_i[3]) begin
      dec_o.chan_wr = wr_i & chan_ok;
      dec_o.chan_rd = rd_only & chan_ok;
    end else if (wr_i) begin
      unique case (addr_i)
        OFS_CMD:        dec_o.cmd_wr      = 1'b1;
        OFS_SGL_MASK:   dec_o.sgl_mask_wr = 1'b1;
        OFS_CLR_PTR:    dec_o.clr_ptr     = 1'b1;
        OFS_MCLR:       dec_o.mclr        = 1'b1;
        OFS_UNMASK_ALL: dec_o.unmask_all  = 1'b1;
        OFS_MASK_ALL:   dec_o.mask_all_wr = 1'b1;
        default:        ;
      endcase
    end else if (rd_only && addr_i == OFS_CMD) begin
      dec_o.stat_rd = 1'b1;
    end
  end
endmodule

// File: rtl/dma_ptr_ff.sv
module dma_ptr_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  input  logic clear_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_o <= 1'b0;
    else if (clear_i)  hi_o <= 1'b0;
    else if (toggle_i) hi_o <= ~hi_o;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic              cnt_wr_i,
  input  logic              hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              reload_i,
  input  logic              step_i,
  output logic [REG_W-1:0]  cur_addr_o,
  output logic [REG_W-1:0]  cur_cnt_o,
  output logic              tc_o
);
  logic [REG_W-1:0] base_addr_q, base_cnt_q;
  logic [REG_W-1:0] cur_addr_q, cur_cnt_q;
  logic             any_wr;

  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] old,
                                               input logic hi,
                                               input logic [BYTE_W-1:0] b);
    return hi ? {b, old[BYTE_W-1:0]} : {old[REG_W-1:BYTE_W], b};
  endfunction

  assign any_wr     = addr_wr_i | cnt_wr_i;
  assign tc_o       = step_i & ~reload_i & ~any_wr & (cur_cnt_q == '0);
  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
    end else begin
      if (addr_wr_i) begin
        base_addr_q <= put_byte(base_addr_q, hi_i, wdata_i);
        cur_addr_q  <= put_byte(cur_addr_q, hi_i, wdata_i);
      end
      if (cnt_wr_i) begin
        base_cnt_q <= put_byte(base_cnt_q, hi_i, wdata_i);
        cur_cnt_q  <= put_byte(cur_cnt_q, hi_i, wdata_i);
      end
      if (!any_wr) begin
        if (reload_i) begin
          cur_addr_q <= base_addr_q;
          cur_cnt_q  <= base_cnt_q;
        end else if (step_i) begin
          cur_addr_q <= cur_addr_q + 1'b1;
          cur_cnt_q  <= cur_cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regport_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic              sgl_mask_wr_i,
  input  logic              unmask_all_i,
  input  logic              mask_all_wr_i,
  input  logic              mclr_i,
  input  logic              stat_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] tc_set_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] tc_o
);
  logic [NUM_CH-1:0] mask_d;

  always_comb begin
    mask_d = mask_o;
    if (mask_all_wr_i)     mask_d = wdata_i[NUM_CH-1:0];
    else if (unmask_all_i) mask_d = '0;
    else if (sgl_mask_wr_i) begin
      for (int i = 0; i < NUM_CH; i++)
        if (wdata_i[1:0] == 2'(i)) mask_d[i] = wdata_i[2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= '0;
      mask_o <= '1;
      tc_o   <= '0;
    end else if (mclr_i) begin
      cmd_o  <= '0;
      mask_o <= '1;
      tc_o   <= '0;
    end else begin
      if (cmd_wr_i) cmd_o <= wdata_i;
      mask_o <= mask_d;
      tc_o   <= (stat_rd_i ? '0 : tc_o) | tc_set_i;
    end
  end
endmodule

// File: rtl/dma_regport.sv
module dma_regport
  import dma_regport_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [OFS_W-1:0]        addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [BYTE_W-1:0]       wdata_i,
  output logic [BYTE_W-1:0]       rdata_o,
  input  logic [NUM_CH-1:0]       step_i,
  input  logic [NUM_CH-1:0]       reload_i,
  output logic [NUM_CH*REG_W-1:0] cur_addr_o,
  output logic [NUM_CH*REG_W-1:0] cur_cnt_o,
  output logic [BYTE_W-1:0]       cmd_o,
  output logic [NUM_CH-1:0]       mask_o,
  output logic [NUM_CH-1:0]       tc_o
);
  localparam int PAD_W = BYTE_W - NUM_CH;

  dec_t              dec;
  logic              ptr_hi;
  logic [NUM_CH-1:0] tc_set;
  logic [REG_W-1:0]  cur_addr_w [NUM_CH];
  logic [REG_W-1:0]  cur_cnt_w  [NUM_CH];
  logic [REG_W-1:0]  rd_word;

  dma_regport_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .dec_o(dec)
  );

  dma_ptr_ff u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .toggle_i (dec.chan_wr | dec.chan_rd),
    .clear_i  (dec.clr_ptr | dec.mclr),
    .hi_o     (ptr_hi)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = (dec.chan == 2'(g));
    dma_chan_regs u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .addr_wr_i  (dec.chan_wr & sel & ~dec.is_cnt),
      .cnt_wr_i   (dec.chan_wr & sel & dec.is_cnt),
      .hi_i       (ptr_hi),
      .wdata_i    (wdata_i),
      .reload_i   (reload_i[g]),
      .step_i     (step_i[g]),
      .cur_addr_o (cur_addr_w[g]),
      .cur_cnt_o  (cur_cnt_w[g]),
      .tc_o       (tc_set[g])
    );
    assign cur_addr_o[g*REG_W +: REG_W] = cur_addr_w[g];
    assign cur_cnt_o[g*REG_W +: REG_W]  = cur_cnt_w[g];
  end

  dma_ctrl_regs #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_wr_i      (dec.cmd_wr),
    .sgl_mask_wr_i (dec.sgl_mask_wr),
    .unmask_all_i  (dec.unmask_all),
    .mask_all_wr_i (dec.mask_all_wr),
    .mclr_i        (dec.mclr),
    .stat_rd_i     (dec.stat_rd),
    .wdata_i       (wdata_i),
    .tc_set_i      (tc_set),
    .cmd_o         (cmd_o),
    .mask_o        (mask_o),
    .tc_o          (tc_o)
  );

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (dec.chan == 2'(i)) rd_word = dec.is_cnt ? cur_cnt_w[i] : cur_addr_w[i];
  end

  always_comb begin
    rdata_o = '0;
    if (dec.chan_rd)      rdata_o = ptr_hi ? rd_word[REG_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
    else if (dec.stat_rd) rdata_o = {{PAD_W{1'b0}}, tc_o};
  end
endmodule

// File: rtl/dma_regport_chk.sv
module dma_regport_chk
  import dma_regport_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [OFS_W-1:0]        addr_i,
  input logic                    wr_i,
  input logic                    rd_i,
  input logic [NUM_CH-1:0]       step_i,
  input logic [NUM_CH-1:0]       reload_i,
  input logic [NUM_CH*REG_W-1:0] cur_addr_o,
  input logic [NUM_CH*REG_W-1:0] cur_cnt_o,
  input logic [BYTE_W-1:0]       cmd_o,
  input logic [NUM_CH-1:0]       mask_o,
  input logic [NUM_CH-1:0]       tc_o,
  input logic                    ptr_hi_i
);
  logic chan_acc, ptr_cmd;
  assign chan_acc = (wr_i | rd_i) & ~addr_i[3] & (int'(addr_i[2:1]) < NUM_CH);
  assign ptr_cmd  = wr_i & (addr_i == OFS_CLR_PTR || addr_i == OFS_MCLR);

  assert_ptr_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_CLR_PTR |=> !ptr_hi_i);

  assert_ptr_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_acc |=> ptr_hi_i != $past(ptr_hi_i));

  assert_ptr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_acc && !ptr_cmd |=> $stable(ptr_hi_i));

  assert_master_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_MCLR |=> mask_o == '1 && cmd_o == '0 && tc_o == '0 && !ptr_hi_i);

  assert_regs_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && step_i == '0 && reload_i == '0 |=> $stable(cur_addr_o) && $stable(cur_cnt_o));

  assert_stat_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && addr_i == OFS_CMD && step_i == '0 |=> tc_o == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_tc_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i[g] && !reload_i[g] && !wr_i && cur_cnt_o[g*REG_W +: REG_W] == '0 |=> tc_o[g]);

    assert_step_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i[g] && !reload_i[g] && !wr_i |=>
        cur_addr_o[g*REG_W +: REG_W] == REG_W'($past(cur_addr_o[g*REG_W +: REG_W]) + 1));
  end
endmodule

bind dma_regport dma_regport_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .step_i(step_i), .reload_i(reload_i), .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o),
  .cmd_o(cmd_o), .mask_o(mask_o), .tc_o(tc_o), .ptr_hi_i(ptr_hi)
);

// File: tb/dma_regport_tb.sv
module dma_regport_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  step = '0, reload = '0;
  logic [63:0] cur_addr, cur_cnt;
  logic [7:0]  cmd;
  logic [3:0]  mask, tc;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  dma_regport u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .step_i(step), .reload_i(reload),
    .cur_addr_o(cur_addr), .cur_cnt_o(cur_cnt), .cmd_o(cmd), .mask_o(mask), .tc_o(tc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ca(input int ch); return cur_addr[ch*16 +: 16]; endfunction
  function automatic logic [15:0] cc(input int ch); return cur_cnt[ch*16 +: 16]; endfunction

  task automatic drive(input bit w, input logic [3:0] a, input logic [7:0] d,
                       input logic [3:0] st, input logic [3:0] rl);
    @(posedge clk); #1;
    wr = w; addr = a; wdata = d; step = st; reload = rl;
    @(posedge clk); #1;
    wr = 0; step = '0; reload = '0;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    drive(1'b1, a, d, 4'h0, 4'h0);
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a; rd = 1'b1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  // monitor: compare read data against the scoreboard mid-cycle
  always @(negedge clk) begin
    if (rst_n && rd) begin
      if (sb_q.size() == 0) chk("R4 unexpected read", 32'h1, 32'h0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, 32'(rdata), 32'(it.exp));
      end
    end else if (rst_n && !rd) begin
      if (rdata !== 8'h00) chk("R4 idle rdata", 32'(rdata), 32'h0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mask", 32'(mask), 32'hF);
    chk("R1 cmd", 32'(cmd), 32'h0);
    chk("R1 tc", 32'(tc), 32'h0);
    chk("R1 addr", cur_addr[31:0], 32'h0);
    chk("R1 cnt", cur_cnt[31:0], 32'h0);

    // R2/R4: ch1 address, low then high
    bus_wr(4'h2, 8'h34); bus_wr(4'h2, 8'h12);
    chk("R2 ch1 addr", 32'(ca(1)), 32'h1234);
    bus_rd(4'h2, 8'h34, "R4 ch1 addr lo");
    bus_rd(4'h2, 8'h12, "R4 ch1 addr hi");

    // R3: clear pointer after a lone low write
    bus_wr(4'h5, 8'hAA); bus_wr(4'hC, 8'hFF);
    bus_wr(4'h5, 8'h55); bus_wr(4'h5, 8'h66);
    chk("R3 ch2 cnt", 32'(cc(2)), 32'h6655);

    // R2: pointer shared across channels
    bus_wr(4'h0, 8'h11); bus_wr(4'h7, 8'h22);
    chk("R2 shared ch0", 32'(ca(0)), 32'h0011);
    chk("R2 shared ch3", 32'(cc(3)), 32'h2200);

    // R10: unused reads return 0 and keep the pointer
    bus_rd(4'h9, 8'h00, "R10 rd 9");
    bus_rd(4'hB, 8'h00, "R10 rd B");
    bus_wr(4'h9, 8'h77); bus_wr(4'hB, 8'h77);
    bus_rd(4'h2, 8'h34, "R10 ptr held lo");
    bus_rd(4'h2, 8'h12, "R10 ptr then hi");

    // R5/R7: command and mask
    bus_wr(4'h8, 8'h5A); chk("R5 cmd", 32'(cmd), 32'h5A);
    bus_wr(4'hF, 8'h00); chk("R7 mask all", 32'(mask), 32'h0);
    bus_wr(4'hA, 8'h06); chk("R7 set ch2", 32'(mask), 32'h4);
    bus_wr(4'hA, 8'h05); chk("R7 set ch1", 32'(mask), 32'h6);
    bus_wr(4'hA, 8'h02); chk("R7 clr ch2", 32'(mask), 32'h2);
    bus_wr(4'hF, 8'h09); chk("R7 load", 32'(mask), 32'h9);
    bus_wr(4'hE, 8'h00); chk("R7 unmask all", 32'(mask), 32'h0);

    // R6: master clear with pointer left high
    bus_wr(4'h6, 8'h77); bus_wr(4'hD, 8'h00);
    chk("R6 mask", 32'(mask), 32'hF);
    chk("R6 cmd", 32'(cmd), 32'h0);
    chk("R6 ch1 kept", 32'(ca(1)), 32'h1234);
    bus_wr(4'h6, 8'h88); bus_wr(4'h6, 8'h99);
    chk("R6 ptr low", 32'(ca(3)), 32'h9988);

    // R8: count 2 gives three steps, address wraps
    bus_wr(4'h0, 8'hFE); bus_wr(4'h0, 8'hFF);
    bus_wr(4'h1, 8'h02); bus_wr(4'h1, 8'h00);
    drive(1'b0, 4'h0, 8'h0, 4'h1, 4'h0);
    drive(1'b0, 4'h0, 8'h0, 4'h1, 4'h0);
    chk("R8 no tc yet", 32'(tc), 32'h0);
    chk("R8 cnt 0", 32'(cc(0)), 32'h0);
    drive(1'b0, 4'h0, 8'h0, 4'h1, 4'h0);
    chk("R8 tc ch0", 32'(tc), 32'h1);
    chk("R8 addr wrap", 32'(ca(0)), 32'h0001);
    chk("R8 cnt wrap", 32'(cc(0)), 32'hFFFF);
    bus_rd(4'h8, 8'h01, "R5 status");
    bus_rd(4'h8, 8'h00, "R5 status cleared");

    // R9: reload, then reload beats step
    drive(1'b0, 4'h0, 8'h0, 4'h0, 4'h1);
    chk("R9 reload addr", 32'(ca(0)), 32'hFFFE);
    bus_rd(4'h1, 8'h02, "R9 reload cnt lo");
    bus_rd(4'h1, 8'h00, "R9 reload cnt hi");
    drive(1'b0, 4'h0, 8'h0, 4'h1, 4'h1);
    chk("R9 reload over step", 32'(ca(0)), 32'hFFFE);
    // write beats step (pointer low)
    drive(1'b1, 4'h2, 8'hAB, 4'h2, 4'h0);
    chk("R9 write over step", 32'(ca(1)), 32'h12AB);
    bus_wr(4'hC, 8'h00);

    // R8: count 0 is one transfer
    bus_wr(4'h7, 8'h00); bus_wr(4'h7, 8'h00);
    drive(1'b0, 4'h0, 8'h0, 4'h8, 4'h0);
    chk("R8 single tc", 32'(tc), 32'h8);
    bus_rd(4'h8, 8'h08, "R5 status ch3");

    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule